// File: doc/BRIEF.md
# Predicated Element Issue Sequencer

This block turns one scalar-encoded operation into a stream of per-element micro-operations for a bank of parallel ALU lanes. The caller presents the already-redirected destination and two source register numbers, a flag per operand saying whether that operand is a vector, a vector length, and a predicate mask. Once the block accepts the operation, it walks the active elements in ascending order. Each clock it hands up to `LANES` of them to the lanes, and each lane carries the element number and the three register indices for that element.

Elements whose predicate bit is clear are skipped and never take a lane. The active ones are packed down into lanes starting at lane 0. The number of issue cycles therefore follows the count of set predicate bits below the vector length, not the vector length. A vector operand's index is its base plus the element number. A scalar operand keeps its base index for every element, so one sequencer serves every mix of scalar and vector operands. A one-cycle `done_o` pulse marks the end of each operation, including operations that have nothing to issue.

Top module: `elem_issue_seq`

## Requirements
- R1: After reset, `ready_o` is 1, `done_o` is 0 and every bit of `lane_valid_o` is 0.
- R2: An operation is accepted only on a clock edge where `start_i` and `ready_o` are both 1. While an operation is in progress `ready_o` is 0, and `start_i` and all operation inputs are ignored; the issue sequence continues unchanged.
- R3: Element i is issued only if i < VL and bit i of `pred_i` is 1. A `vl_i` value above XLEN acts as XLEN.
- R4: Each issue cycle takes the lowest-numbered active elements not yet issued, at most `LANES` of them, in ascending element order. The first issue cycle follows the accepting edge by one clock, later issue cycles come back to back, and there are ceil(active/LANES) of them.
- R5: A lane's destination and source index equals that operand's base plus the element number when the operand's vector flag is 1, and equals the base when the flag is 0.
- R6: Lanes fill from lane 0 upward with no gaps. Lane j is valid only if every lane below j is valid. Lanes are all invalid outside issue cycles.
- R7: `done_o` is 1 for exactly one cycle, the cycle after the final issue cycle. `ready_o` returns to 1 in that same cycle and no lane is valid then.
- R8: An operation with no active element (VL of 0, or no set bit below VL) issues nothing. It raises `done_o` in the cycle right after the accepting edge, and `ready_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin an operation |
| ready_o | output | 1 | Idle and able to accept an operation |
| rd_i | input | REGW | Destination base register index |
| rs1_i | input | REGW | First source base register index |
| rs2_i | input | REGW | Second source base register index |
| rd_vec_i | input | 1 | Destination steps per element |
| rs1_vec_i | input | 1 | First source steps per element |
| rs2_vec_i | input | 1 | Second source steps per element |
| vl_i | input | clog2(XLEN+1) | Vector length |
| pred_i | input | XLEN | Predicate mask, bit i enables element i |
| lane_valid_o | output | LANES | Lane carries an element this cycle |
| lane_elem_o | output | LANES*clog2(XLEN) | Element number per lane, lane 0 in the low bits |
| lane_rd_o | output | LANES*IW | Destination index per lane |
| lane_rs1_o | output | LANES*IW | First source index per lane |
| lane_rs2_o | output | LANES*IW | Second source index per lane |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
All outputs are registered. The bench drives inputs one time unit after a rising edge and samples one time unit after the following edge. From the accepting edge it expects this sequence: one cycle with no valid lane and `ready_o` low, then one sampling point per expected issue cycle, then the `done_o` cycle with `ready_o` high. An empty operation moves straight to the `done_o` cycle. The bench builds each expected issue cycle by scanning the remaining predicate bits from the bottom, and it also checks that `done_o` has fallen one cycle later. Some runs assert `start_i` with different operands during an issue sequence, and the expected sequence stays the one computed from the accepted operation.

// File: rtl/elem_issue_pkg.sv
package elem_issue_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/eis_lowbit_pick.sv
// Finds the lowest set bit of a pool, returns its position and the pool without it.
module eis_lowbit_pick #(
  parameter int W  = 64,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  pool_i,
  output logic          found_o,
  output logic [PW-1:0] idx_o,
  output logic [W-1:0]  rest_o
);
  logic [W-1:0] iso;

  always_comb begin
    iso     = pool_i & (~pool_i + W'(1));
    found_o = |pool_i;
    rest_o  = pool_i & ~iso;
    idx_o   = '0;
    for (int i = 0; i < W; i++) begin
      if (iso[i]) idx_o = PW'(i);
    end
  end
endmodule

// File: rtl/eis_index_gen.sv
// Register index of one operand for one element.
module eis_index_gen #(
  parameter int REGW = 5,
  parameter int EW   = 6,
  parameter int IW   = 7
) (
  input  logic [REGW-1:0] base_i,
  input  logic            vec_i,
  input  logic [EW-1:0]   elem_i,
  output logic [IW-1:0]   idx_o
);
  always_comb begin
    if (vec_i) idx_o = IW'(base_i) + IW'(elem_i);
    else       idx_o = IW'(base_i);
  end
endmodule

// File: rtl/elem_issue_seq.sv
module elem_issue_seq
  import elem_issue_pkg::*;
#(
  parameter int LANES = 4,
  parameter int XLEN  = 64,
  parameter int REGW  = 5,
  localparam int EW   = $clog2(XLEN),
  localparam int VW   = $clog2(XLEN + 1),
  localparam int IW   = $clog2((1 << REGW) + XLEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  output logic                ready_o,
  input  logic [REGW-1:0]     rd_i,
  input  logic [REGW-1:0]     rs1_i,
  input  logic [REGW-1:0]     rs2_i,
  input  logic                rd_vec_i,
  input  logic                rs1_vec_i,
  input  logic                rs2_vec_i,
  input  logic [VW-1:0]       vl_i,
  input  logic [XLEN-1:0]     pred_i,
  output logic [LANES-1:0]    lane_valid_o,
  output logic [LANES*EW-1:0] lane_elem_o,
  output logic [LANES*IW-1:0] lane_rd_o,
  output logic [LANES*IW-1:0] lane_rs1_o,
  output logic [LANES*IW-1:0] lane_rs2_o,
  output logic                done_o
);

  seq_state_t        state_q;
  logic [XLEN-1:0]   remain_q;
  logic [REGW-1:0]   rd_q, rs1_q, rs2_q;
  logic              rd_vec_q, rs1_vec_q, rs2_vec_q;
  logic              last_q;
  logic              done_q;

  logic [XLEN-1:0]   vl_mask;
  logic [XLEN-1:0]   active;
  logic [XLEN-1:0]   pool [0:LANES];
  logic [LANES-1:0]  pick_found;
  logic [EW-1:0]     pick_idx [LANES];
  logic [IW-1:0]     nxt_rd [LANES];
  logic [IW-1:0]     nxt_rs1 [LANES];
  logic [IW-1:0]     nxt_rs2 [LANES];

  logic [LANES-1:0]  valid_q;
  logic [EW-1:0]     elem_q [LANES];
  logic [IW-1:0]     rd_idx_q [LANES];
  logic [IW-1:0]     rs1_idx_q [LANES];
  logic [IW-1:0]     rs2_idx_q [LANES];

  // Elements at or above the vector length never run; lengths past XLEN saturate.
  always_comb begin
    for (int i = 0; i < XLEN; i++) vl_mask[i] = (VW'(i) < vl_i);
    active = pred_i & vl_mask;
  end

  assign pool[0] = remain_q;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      eis_lowbit_pick #(.W(XLEN), .PW(EW)) u_pick (
        .pool_i (pool[k]),
        .found_o(pick_found[k]),
        .idx_o  (pick_idx[k]),
        .rest_o (pool[k+1])
      );
      eis_index_gen #(.REGW(REGW), .EW(EW), .IW(IW)) u_rd (
        .base_i(rd_q), .vec_i(rd_vec_q), .elem_i(pick_idx[k]), .idx_o(nxt_rd[k])
      );
      eis_index_gen #(.REGW(REGW), .EW(EW), .IW(IW)) u_rs1 (
        .base_i(rs1_q), .vec_i(rs1_vec_q), .elem_i(pick_idx[k]), .idx_o(nxt_rs1[k])
      );
      eis_index_gen #(.REGW(REGW), .EW(EW), .IW(IW)) u_rs2 (
        .base_i(rs2_q), .vec_i(rs2_vec_q), .elem_i(pick_idx[k]), .idx_o(nxt_rs2[k])
      );
      assign lane_elem_o[k*EW +: EW] = elem_q[k];
      assign lane_rd_o[k*IW +: IW]   = rd_idx_q[k];
      assign lane_rs1_o[k*IW +: IW]  = rs1_idx_q[k];
      assign lane_rs2_o[k*IW +: IW]  = rs2_idx_q[k];
    end
  endgenerate

  assign ready_o      = (state_q == ST_IDLE) && !last_q;
  assign lane_valid_o = valid_q;
  assign done_o       = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      remain_q  <= '0;
      rd_q      <= '0;
      rs1_q     <= '0;
      rs2_q     <= '0;
      rd_vec_q  <= 1'b0;
      rs1_vec_q <= 1'b0;
      rs2_vec_q <= 1'b0;
      last_q    <= 1'b0;
      done_q    <= 1'b0;
      valid_q   <= '0;
      for (int k = 0; k < LANES; k++) begin
        elem_q[k]    <= '0;
        rd_idx_q[k]  <= '0;
        rs1_idx_q[k] <= '0;
        rs2_idx_q[k] <= '0;
      end
    end else begin
      done_q  <= last_q;
      last_q  <= 1'b0;
      valid_q <= '0;
      case (state_q)
        ST_IDLE: begin
          if (start_i && ready_o) begin
            remain_q  <= active;
            rd_q      <= rd_i;
            rs1_q     <= rs1_i;
            rs2_q     <= rs2_i;
            rd_vec_q  <= rd_vec_i;
            rs1_vec_q <= rs1_vec_i;
            rs2_vec_q <= rs2_vec_i;
            if (active == '0) done_q  <= 1'b1;
            else              state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          valid_q  <= pick_found;
          remain_q <= pool[LANES];
          for (int k = 0; k < LANES; k++) begin
            elem_q[k]    <= pick_idx[k];
            rd_idx_q[k]  <= nxt_rd[k];
            rs1_idx_q[k] <= nxt_rs1[k];
            rs2_idx_q[k] <= nxt_rs2[k];
          end
          if (pool[LANES] == '0) begin
            state_q <= ST_IDLE;
            last_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/elem_issue_seq_chk.sv
module elem_issue_seq_chk #(
  parameter int LANES = 4,
  parameter int EW    = 6,
  parameter int IW    = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                ready,
  input logic                done,
  input logic [LANES-1:0]    lane_valid,
  input logic [LANES*EW-1:0] lane_elem,
  input logic [LANES*IW-1:0] lane_rd,
  input logic [LANES*IW-1:0] lane_rs1,
  input logic [LANES*IW-1:0] lane_rs2
);

  a_r8_done_implies_ready: assert property (@(posedge clk) disable iff (rst)
    done |-> ready);

  a_r7_done_no_lanes: assert property (@(posedge clk) disable iff (rst)
    done |-> (lane_valid == '0));

  a_r2_not_ready_while_issuing: assert property (@(posedge clk) disable iff (rst)
    (|lane_valid) |-> !ready);

  generate
    for (genvar j = 0; j + 1 < LANES; j++) begin : g_pair
      a_r6_lanes_packed: assert property (@(posedge clk) disable iff (rst)
        lane_valid[j+1] |-> lane_valid[j]);

      a_r4_ascending_elems: assert property (@(posedge clk) disable iff (rst)
        lane_valid[j+1] |-> (lane_elem[j*EW +: EW] < lane_elem[(j+1)*EW +: EW]));

      a_r5_rd_step: assert property (@(posedge clk) disable iff (rst)
        lane_valid[j+1] |->
          ((lane_rd[(j+1)*IW +: IW] == lane_rd[j*IW +: IW]) ||
           (lane_rd[(j+1)*IW +: IW] - lane_rd[j*IW +: IW] ==
            IW'(lane_elem[(j+1)*EW +: EW] - lane_elem[j*EW +: EW]))));

      a_r5_rs1_step: assert property (@(posedge clk) disable iff (rst)
        lane_valid[j+1] |->
          ((lane_rs1[(j+1)*IW +: IW] == lane_rs1[j*IW +: IW]) ||
           (lane_rs1[(j+1)*IW +: IW] - lane_rs1[j*IW +: IW] ==
            IW'(lane_elem[(j+1)*EW +: EW] - lane_elem[j*EW +: EW]))));

      a_r5_rs2_step: assert property (@(posedge clk) disable iff (rst)
        lane_valid[j+1] |->
          ((lane_rs2[(j+1)*IW +: IW] == lane_rs2[j*IW +: IW]) ||
           (lane_rs2[(j+1)*IW +: IW] - lane_rs2[j*IW +: IW] ==
            IW'(lane_elem[(j+1)*EW +: EW] - lane_elem[j*EW +: EW]))));
    end
  endgenerate

endmodule

bind elem_issue_seq elem_issue_seq_chk #(.LANES(LANES), .EW(EW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready_o),
  .done      (done_o),
  .lane_valid(lane_valid_o),
  .lane_elem (lane_elem_o),
  .lane_rd   (lane_rd_o),
  .lane_rs1  (lane_rs1_o),
  .lane_rs2  (lane_rs2_o)
);

// File: tb/sim_elem_issue_seq.sv
`timescale 1ns/1ps
module sim_elem_issue_seq;
  localparam int LANES = 4;
  localparam int XLEN  = 64;
  localparam int REGW  = 5;
  localparam int EW    = $clog2(XLEN);
  localparam int VW    = $clog2(XLEN + 1);
  localparam int IW    = $clog2((1 << REGW) + XLEN);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [REGW-1:0] rd_i = '0, rs1_i = '0, rs2_i = '0;
  logic rd_vec_i = 1'b0, rs1_vec_i = 1'b0, rs2_vec_i = 1'b0;
  logic [VW-1:0] vl_i = '0;
  logic [XLEN-1:0] pred_i = '0;
  logic ready_o, done_o;
  logic [LANES-1:0] lane_valid_o;
  logic [LANES*EW-1:0] lane_elem_o;
  logic [LANES*IW-1:0] lane_rd_o, lane_rs1_o, lane_rs2_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  elem_issue_seq #(.LANES(LANES), .XLEN(XLEN), .REGW(REGW)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .ready_o(ready_o),
    .rd_i(rd_i), .rs1_i(rs1_i), .rs2_i(rs2_i),
    .rd_vec_i(rd_vec_i), .rs1_vec_i(rs1_vec_i), .rs2_vec_i(rs2_vec_i),
    .vl_i(vl_i), .pred_i(pred_i),
    .lane_valid_o(lane_valid_o), .lane_elem_o(lane_elem_o),
    .lane_rd_o(lane_rd_o), .lane_rs1_o(lane_rs1_o), .lane_rs2_o(lane_rs2_o),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] active_of(input int vl, input logic [XLEN-1:0] p);
    logic [XLEN-1:0] m = '0;
    for (int i = 0; i < XLEN; i++) if (i < vl) m[i] = 1'b1;
    return m & p;
  endfunction

  function automatic int exp_idx(input int base, input bit vec, input int e);
    return vec ? base + e : base;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Runs one operation; if poke is set, start is pulsed with other operands mid-run (R2).
  task automatic run_op(input int rd, input int rs1, input int rs2,
                        input bit rdv, input bit r1v, input bit r2v,
                        input int vl, input logic [XLEN-1:0] pred, input bit poke);
    logic [XLEN-1:0] rem;
    int nact;
    chk(ready_o === 1'b1, "R2", "ready before start", longint'(ready_o), 1);
    rd_i = REGW'(rd); rs1_i = REGW'(rs1); rs2_i = REGW'(rs2);
    rd_vec_i = rdv; rs1_vec_i = r1v; rs2_vec_i = r2v;
    vl_i = VW'(vl); pred_i = pred; start_i = 1'b1;
    rem = active_of(vl, pred);
    nact = $countones(rem);
    step();
    start_i = 1'b0;
    if (nact == 0) begin
      chk(done_o === 1'b1, "R8", "done after empty op", longint'(done_o), 1);
      chk(ready_o === 1'b1, "R8", "ready stays high", longint'(ready_o), 1);
      chk(lane_valid_o === '0, "R8", "no lanes for empty op", longint'(lane_valid_o), 0);
      step();
      chk(done_o === 1'b0, "R7", "done single cycle", longint'(done_o), 0);
      return;
    end
    chk(ready_o === 1'b0, "R2", "busy after accept", longint'(ready_o), 0);
    chk(lane_valid_o === '0, "R4", "no lanes in accept cycle", longint'(lane_valid_o), 0);
    chk(done_o === 1'b0, "R7", "no done while busy", longint'(done_o), 0);
    if (poke) begin
      start_i = 1'b1; rd_i = ~rd_i; vl_i = VW'(XLEN); pred_i = '1;
      rd_vec_i = ~rd_vec_i; rs1_vec_i = ~rs1_vec_i;
    end
    while (rem != '0) begin
      int got = 0;
      int el [LANES];
      for (int i = 0; i < XLEN; i++) begin
        if (rem[i] && got < LANES) begin
          el[got] = i;
          rem[i] = 1'b0;
          got++;
        end
      end
      step();
      start_i = 1'b0;
      for (int j = 0; j < LANES; j++) begin
        logic v = lane_valid_o[j];
        chk(v === (j < got), "R6", $sformatf("lane %0d valid", j), longint'(v), longint'(j < got));
        if (j < got) begin
          chk(lane_elem_o[j*EW +: EW] == EW'(el[j]), "R4", $sformatf("lane %0d element", j),
              longint'(lane_elem_o[j*EW +: EW]), el[j]);
          chk(lane_rd_o[j*IW +: IW] == IW'(exp_idx(rd, rdv, el[j])), "R5", "rd index",
              longint'(lane_rd_o[j*IW +: IW]), exp_idx(rd, rdv, el[j]));
          chk(lane_rs1_o[j*IW +: IW] == IW'(exp_idx(rs1, r1v, el[j])), "R5", "rs1 index",
              longint'(lane_rs1_o[j*IW +: IW]), exp_idx(rs1, r1v, el[j]));
          chk(lane_rs2_o[j*IW +: IW] == IW'(exp_idx(rs2, r2v, el[j])), "R5", "rs2 index",
              longint'(lane_rs2_o[j*IW +: IW]), exp_idx(rs2, r2v, el[j]));
        end
      end
      chk(done_o === 1'b0, "R7", "no done during issue", longint'(done_o), 0);
    end
    step();
    chk(done_o === 1'b1, "R7", "done after final beat", longint'(done_o), 1);
    chk(ready_o === 1'b1, "R7", "ready with done", longint'(ready_o), 1);
    chk(lane_valid_o === '0, "R3", "no extra beat", longint'(lane_valid_o), 0);
    step();
    chk(done_o === 1'b0, "R7", "done single cycle", longint'(done_o), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(ready_o === 1'b1, "R1", "ready after reset", longint'(ready_o), 1);
    chk(done_o === 1'b0, "R1", "done after reset", longint'(done_o), 0);
    chk(lane_valid_o === '0, "R1", "lanes after reset", longint'(lane_valid_o), 0);
    step();

    run_op(3, 7, 9, 1, 1, 0, 0, '1, 0);                     // R8 VL zero
    run_op(3, 7, 9, 1, 1, 1, 64, '0, 0);                    // R8 empty mask
    run_op(1, 2, 3, 1, 0, 1, 8, 64'hDB, 0);                 // R4 six of eight: 4 then 2
    run_op(31, 31, 0, 1, 1, 1, 70, '1, 0);                  // R3 VL above XLEN saturates
    run_op(5, 6, 7, 0, 0, 0, 1, 64'h1, 0);                  // R5 scalar-scalar, single element
    run_op(4, 8, 12, 1, 0, 0, 64, 64'h8000_0000_0000_0000, 0); // R3 top element only
    run_op(4, 8, 12, 1, 1, 1, 10, 64'hFFFF_FC00, 0);        // R3 all set bits above VL
    run_op(2, 10, 20, 1, 1, 0, 40, 64'h00F0_0F00_F00F, 1);  // R2 start during busy
    run_op(0, 0, 0, 0, 0, 0, 0, '0, 0);                     // R8 back to back empty

    for (int t = 0; t < 300; t++) begin
      logic [XLEN-1:0] p;
      int vl;
      p = {$urandom(), $urandom()};
      case ($urandom_range(3))
        0: p = p & {$urandom(), $urandom()};
        1: p = p | {$urandom(), $urandom()};
        default: ;
      endcase
      vl = $urandom_range(XLEN + 3);
      run_op($urandom_range(31), $urandom_range(31), $urandom_range(31),
             1'($urandom()), 1'($urandom()), 1'($urandom()), vl, p,
             ($urandom_range(7) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule